// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the hardware producer of a receive descriptor ring held in system memory. Software sets up an array of two-word descriptors (a buffer pointer followed by a control word holding the buffer size minus one), a parallel array of two-word status entries, the index of the last ring slot (entry count minus one), and a consume index that it moves forward as it takes frames away. The block owns the produce index.

When a frame starts on the byte-stream input, the block checks whether the ring has room. If it does, it fetches the descriptor at the produce index, packs incoming bytes little-endian into 32-bit words and writes them into the buffer, writes the status entry and only then advances the produce index, wrapping after the last slot. If the ring is full, the frame is swallowed without touching memory and a one-cycle overrun pulse is raised. Frames longer than the buffer are cut at the buffer end and marked in the status.

Memory is reached through one word-wide request port: the block raises a request with address, direction and write data, holds them, and the access completes in the cycle the acknowledge is sampled high (read data is taken in that cycle).

Top module: `rxr_desc_writer`

## Requirements
- R1: After reset the produce index is 0, no memory request is raised, the overrun pulse is low and the byte input is not ready while no byte is offered.
- R2: For a frame accepted into slot k, the first two memory accesses are reads of address desc_base+8k (buffer pointer) and desc_base+8k+4 (control word, bits 10:0 = buffer size minus one), both before any byte is accepted.
- R3: Stored frame bytes are written to consecutive words from the buffer pointer upward, byte n of the frame in bits 8*(n mod 4)+7:8*(n mod 4) of word n/4; the byte input is never ready while a memory request is pending.
- R4: The status info word is written to stat_base+8k with bits 10:0 = stored length minus one, and the word at stat_base+8k+4 is written as zero.
- R5: If the error flag was high on any byte of the frame, bit 23 of the status info word is set, otherwise it is clear.
- R6: A frame longer than the buffer size stores exactly the buffer size bytes, writes no word past the last one holding a stored byte, and sets bit 27 of the status info word (clear otherwise).
- R7: The produce index advances by one, from the last slot to 0, only in the cycle after the second status word's write is acknowledged.
- R8: When a frame starts while (produce+1) modulo the entry count equals the consume index, the frame is consumed without any memory access, the produce index is unchanged, and the overrun output pulses high for one cycle.
- R9: A memory request keeps its address, direction and write data unchanged until acknowledged.
- R10: Bytes offered without the start flag while no frame is in progress are accepted and discarded with no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_base | input | AW | Byte address of descriptor array |
| stat_base | input | AW | Byte address of status array |
| ring_last | input | IDX_W | Index of the last ring slot (count minus one) |
| cons_idx | input | IDX_W | Software consume index |
| prod_idx | output | IDX_W | Hardware produce index |
| in_valid | input | 1 | Byte offered |
| in_sof | input | 1 | Byte is first of a frame |
| in_eof | input | 1 | Byte is last of a frame |
| in_err | input | 1 | Frame error flag for this byte |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte accepted at this edge when high with in_valid |
| overrun | output | 1 | One-cycle pulse when a frame is dropped on a full ring |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The hardest state to reach is a full ring: it takes several completed frames while the consume index is held back, so the stimulus deliberately leaves the consume index at zero through three directed frames before offering a fourth, then releases the slots and sends a frame into the last slot to force the wrap. Truncation in the middle of a word, at a word edge and at a one-byte buffer is placed directly, while random frames with random buffer sizes, error flags and acknowledge latencies of zero to two cycles cover the remaining mix.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RDPTR, S_RDCTL, S_RECV, S_WRDATA, S_WRSTAT, S_WRHASH, S_DROP
    } rxr_state_e;

    typedef enum logic [2:0] {
        A_DPTR, A_DCTL, A_DATA, A_SINF, A_SHSH
    } rxr_addr_e;

    localparam int STAT_ERR_BIT   = 23;
    localparam int STAT_TRUNC_BIT = 27;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ring_last,
    input  logic [IDX_W-1:0] cons_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] prod_idx,
    output logic             full
);
    logic [IDX_W-1:0] prod_d, prod_q, step;

    always_comb begin
        step   = (prod_q == ring_last) ? '0 : prod_q + 1'b1;
        full   = (step == cons_idx);
        prod_d = advance ? step : prod_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_d;
    end

    assign prod_idx = prod_q;
endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen #(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input  rxr_pkg::rxr_addr_e kind,
    input  logic [AW-1:0]      desc_base,
    input  logic [AW-1:0]      stat_base,
    input  logic [IDX_W-1:0]   slot,
    input  logic [AW-1:0]      buf_ptr,
    input  logic [AW-1:0]      data_off,
    output logic [AW-1:0]      addr
);
    import rxr_pkg::*;
    localparam int ENTRY_SH = 3;
    logic [AW-1:0] slot_off;

    always_comb begin
        slot_off = AW'(slot) << ENTRY_SH;
        case (kind)
            A_DPTR:  addr = desc_base + slot_off;
            A_DCTL:  addr = desc_base + slot_off + AW'(4);
            A_DATA:  addr = buf_ptr + data_off;
            A_SINF:  addr = stat_base + slot_off;
            default: addr = stat_base + slot_off + AW'(4);
        endcase
    end
endmodule

// File: rtl/rxr_desc_writer.sv
module rxr_desc_writer #(
    parameter int AW    = 32,
    parameter int IDX_W = 4,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    desc_base,
    input  logic [AW-1:0]    stat_base,
    input  logic [IDX_W-1:0] ring_last,
    input  logic [IDX_W-1:0] cons_idx,
    output logic [IDX_W-1:0] prod_idx,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_err,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             overrun,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata
);
    import rxr_pkg::*;

    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        rxr_state_e       st;
        logic [AW-1:0]    bptr;
        logic [LEN_W-1:0] bsz;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      word;
        logic             last;
        logic             err;
        logic             trunc;
        logic             ovr;
    } ctx_t;

    ctx_t       ctx_d, ctx_q;
    logic       advance, full;
    logic [1:0] lane;
    logic [31:0] info;
    logic [AW-1:0] data_off;
    rxr_addr_e  kind;

    rxr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ring_last(ring_last), .cons_idx(cons_idx),
        .advance(advance), .prod_idx(prod_idx), .full(full)
    );

    rxr_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
        .kind(kind), .desc_base(desc_base), .stat_base(stat_base), .slot(prod_idx),
        .buf_ptr(ctx_q.bptr), .data_off(data_off), .addr(mem_addr)
    );

    // status info word and buffer offset of the word being flushed
    always_comb begin
        lane     = ctx_q.cnt[1:0];
        data_off = AW'(ctx_q.cnt - 1'b1) & ~AW'(3);
        info     = '0;
        info[LEN_W-1:0]      = ctx_q.cnt[LEN_W-1:0] - 1'b1;
        info[STAT_ERR_BIT]   = ctx_q.err;
        info[STAT_TRUNC_BIT] = ctx_q.trunc;
    end

    // next-state logic
    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.ovr = 1'b0;
        advance   = 1'b0;
        case (ctx_q.st)
            S_IDLE: begin
                ctx_d.cnt   = '0;
                ctx_d.word  = '0;
                ctx_d.last  = 1'b0;
                ctx_d.err   = 1'b0;
                ctx_d.trunc = 1'b0;
                if (in_valid && in_sof) begin
                    if (full) begin
                        ctx_d.st  = S_DROP;
                        ctx_d.ovr = 1'b1;
                    end else begin
                        ctx_d.st = S_RDPTR;
                    end
                end
            end
            S_RDPTR: if (mem_ack) begin
                ctx_d.bptr = AW'(mem_rdata);
                ctx_d.st   = S_RDCTL;
            end
            S_RDCTL: if (mem_ack) begin
                ctx_d.bsz = mem_rdata[LEN_W-1:0];
                ctx_d.st  = S_RECV;
            end
            S_RECV: if (in_valid) begin
                ctx_d.err  = ctx_q.err | in_err;
                ctx_d.last = in_eof;
                if (ctx_q.cnt <= CNT_W'(ctx_q.bsz)) begin
                    ctx_d.word = ctx_q.word | (32'(in_data) << (8 * lane));
                    ctx_d.cnt  = ctx_q.cnt + 1'b1;
                    if (lane == 2'd3 || in_eof || ctx_q.cnt == CNT_W'(ctx_q.bsz))
                        ctx_d.st = S_WRDATA;
                end else begin
                    ctx_d.trunc = 1'b1;
                    if (in_eof) ctx_d.st = S_WRSTAT;
                end
            end
            S_WRDATA: if (mem_ack) begin
                ctx_d.word = '0;
                ctx_d.st   = ctx_q.last ? S_WRSTAT : S_RECV;
            end
            S_WRSTAT: if (mem_ack) ctx_d.st = S_WRHASH;
            S_WRHASH: if (mem_ack) begin
                advance  = 1'b1;
                ctx_d.st = S_IDLE;
            end
            S_DROP: if (in_valid && in_eof) ctx_d.st = S_IDLE;
            default: ctx_d.st = S_IDLE;
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        kind      = A_DPTR;
        case (ctx_q.st)
            S_IDLE:   in_ready = in_valid && !in_sof;
            S_RECV,
            S_DROP:   in_ready = 1'b1;
            S_RDPTR:  begin mem_req = 1'b1; kind = A_DPTR; end
            S_RDCTL:  begin mem_req = 1'b1; kind = A_DCTL; end
            S_WRDATA: begin mem_req = 1'b1; mem_we = 1'b1; kind = A_DATA; mem_wdata = ctx_q.word; end
            S_WRSTAT: begin mem_req = 1'b1; mem_we = 1'b1; kind = A_SINF; mem_wdata = info; end
            S_WRHASH: begin mem_req = 1'b1; mem_we = 1'b1; kind = A_SHSH; end
            default:  ;
        endcase
    end

    assign overrun = ctx_q.ovr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.st <= S_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end
endmodule

// File: rtl/rxr_desc_writer_chk.sv
module rxr_desc_writer_chk #(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] ring_last,
    input logic [IDX_W-1:0] prod_idx,
    input logic             in_ready,
    input logic             overrun,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack
);
    // R9: request fields held until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R7: produce index moves by one slot with wrap
    p_prod_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prod_idx) |-> prod_idx == (($past(prod_idx) == ring_last) ? '0 : $past(prod_idx) + 1'b1));

    // R7: produce index moves only after an acknowledged write
    p_prod_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prod_idx) |-> $past(mem_req && mem_we && mem_ack));

    // R8: a dropped frame makes no memory access
    p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !mem_req && in_ready);

    // R3: bytes are never taken while memory is busy
    p_ready_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req);
endmodule

bind rxr_desc_writer rxr_desc_writer_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_last(ring_last), .prod_idx(prod_idx),
    .in_ready(in_ready), .overrun(overrun), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_rxr_desc_writer.sv
module tb_rxr_desc_writer;
    localparam int AW = 32, IDX_W = 4;
    localparam logic [31:0] DESC = 32'h100, STAT = 32'h200, BUF0 = 32'h1000;
    localparam logic [31:0] SENT = 32'hA5A5A5A5;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] desc_base = DESC, stat_base = STAT;
    logic [IDX_W-1:0] ring_last = 4'd3, cons_idx = '0, prod_idx;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0, in_ready, overrun;
    logic [7:0] in_data = 0;
    logic mem_req, mem_we, mem_ack = 0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = 0;

    always #2 clk = ~clk;

    rxr_desc_writer #(.AW(AW), .IDX_W(IDX_W)) dut (.*);

    logic [31:0] mem [0:8191];
    logic [31:0] log_addr [0:1023];
    logic        log_we   [0:1023];
    int n_acc = 0, n_ovr = 0, hs_bad = 0;
    int checks = 0, fails = 0;
    logic [7:0] fb [0:63];
    logic [IDX_W-1:0] exp_prod = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model with random acknowledge latency and handshake monitor
    initial begin
        int wait_n = 0;
        bit pend = 0;
        logic [31:0] pa = 0;
        forever begin
            @(negedge clk);
            if (pend && (!mem_req || mem_addr != pa)) hs_bad++;
            if (mem_ack) mem_ack = 0;
            else if (mem_req) begin
                if (wait_n == 0) begin
                    if (mem_we) mem[mem_addr[14:2]] = mem_wdata;
                    else mem_rdata = mem[mem_addr[14:2]];
                    log_addr[n_acc % 1024] = mem_addr;
                    log_we[n_acc % 1024] = mem_we;
                    n_acc++;
                    mem_ack = 1;
                    wait_n = $urandom % 3;
                end else wait_n--;
            end
            pend = mem_req && !mem_ack;
            pa = mem_addr;
            if (overrun) n_ovr++;
        end
    end

    function automatic logic [31:0] exp_info(int len, int size, bit err);
        int st = (len > size) ? size : len;
        logic [31:0] v = 32'(st - 1) & 32'h7FF;
        v[23] = err;
        v[27] = (len > size);
        return v;
    endfunction

    task automatic put_byte(input logic [7:0] d, input bit s, input bit e, input bit er);
        @(negedge clk);
        in_valid = 1; in_sof = s; in_eof = e; in_err = er; in_data = d;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
    endtask

    task automatic send(int len, bit err);
        for (int i = 0; i < len; i++) begin
            fb[i] = 8'($urandom);
            put_byte(fb[i], i == 0, i == len - 1, err && (i == len - 1));
        end
    endtask

    task automatic wait_prod(input logic [IDX_W-1:0] old);
        int t = 0;
        while (prod_idx == old && t < 2000) begin @(negedge clk); t++; end
    endtask

    task automatic run_frame(int len, int size, bit err);
        int slot = int'(exp_prod);
        int start, st, bad = 0;
        logic [31:0] bp = BUF0 + 32'(slot * 256);
        mem[(DESC + 32'(slot * 8)) >> 2] = bp;
        mem[(DESC + 32'(slot * 8) + 4) >> 2] = ({$urandom} & 32'h8000_0000) | 32'(size - 1);
        mem[(STAT + 32'(slot * 8)) >> 2] = 32'hFFFF_FFFF;
        mem[(STAT + 32'(slot * 8) + 4) >> 2] = 32'hFFFF_FFFF;
        for (int w = 0; w < 64; w++) mem[(bp >> 2) + w] = SENT;
        start = n_acc;
        send(len, err);
        wait_prod(exp_prod);
        exp_prod = (exp_prod == ring_last) ? '0 : exp_prod + 1'b1;
        chk(log_addr[start % 1024] == DESC + 32'(slot * 8) && !log_we[start % 1024] &&
            log_addr[(start + 1) % 1024] == DESC + 32'(slot * 8) + 4 && !log_we[(start + 1) % 1024],
            "R2", "descriptor reads", log_addr[start % 1024], DESC + 32'(slot * 8));
        st = (len > size) ? size : len;
        for (int i = 0; i < st; i++)
            if (mem[(bp >> 2) + i / 4][8 * (i % 4) +: 8] != fb[i]) bad++;
        chk(bad == 0, "R3", "buffer bytes", 32'(bad), 0);
        chk(mem[(bp >> 2) + (st + 3) / 4] == SENT, "R6", "no write past stored data",
            mem[(bp >> 2) + (st + 3) / 4], SENT);
        chk(mem[(STAT + 32'(slot * 8)) >> 2] == exp_info(len, size, err), "R4 R5 R6", "status info",
            mem[(STAT + 32'(slot * 8)) >> 2], exp_info(len, size, err));
        chk(mem[(STAT + 32'(slot * 8) + 4) >> 2] == 0, "R4", "hash word",
            mem[(STAT + 32'(slot * 8) + 4) >> 2], 0);
        chk(prod_idx == exp_prod, "R7", "produce index", 32'(prod_idx), 32'(exp_prod));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int a0, o0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8192; i++) mem[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(prod_idx == 0 && !mem_req && !in_ready && !overrun, "R1", "reset state",
            {prod_idx, 3'b0, mem_req, 3'b0, in_ready, 3'b0, overrun}, 0);

        run_frame(5, 16, 0);            // slot 0, partial word
        run_frame(20, 8, 0);            // slot 1, truncated at word edge
        // R10: stray bytes without start flag
        a0 = n_acc;
        for (int i = 0; i < 3; i++) put_byte(8'($urandom), 0, i == 2, 0);
        repeat (4) @(negedge clk);
        chk(n_acc == a0 && prod_idx == exp_prod, "R10", "stray bytes ignored", 32'(n_acc - a0), 0);
        run_frame(7, 32, 1);            // slot 2, error flag

        // R8: ring full (prod 3, cons 0)
        a0 = n_acc; o0 = n_ovr;
        send(6, 0);
        repeat (6) @(negedge clk);
        chk(n_acc == a0, "R8", "no access on full ring", 32'(n_acc - a0), 0);
        chk(n_ovr == o0 + 1, "R8", "overrun pulse count", 32'(n_ovr - o0), 1);
        chk(prod_idx == exp_prod, "R8", "produce index held", 32'(prod_idx), 32'(exp_prod));

        @(negedge clk); cons_idx = 4'd3;
        run_frame(1, 1, 0);             // slot 3, one-byte buffer, wraps to 0
        chk(prod_idx == 0, "R7", "wrap to zero", 32'(prod_idx), 0);
        @(negedge clk); cons_idx = prod_idx;
        run_frame(9, 5, 0);             // truncated mid-word
        @(negedge clk); cons_idx = prod_idx;

        for (int k = 0; k < 40; k++) begin
            run_frame(1 + $urandom % 48, 1 + $urandom % 40, ($urandom % 5) == 0);
            @(negedge clk); cons_idx = prod_idx;
        end

        chk(hs_bad == 0, "R9", "request held until ack", 32'(hs_bad), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule